// File: doc/BRIEF.md
# Blocking-Miss Processor Run Controller

This block is the run controller for a single-issue core that executes at most one instruction per cycle and blocks whenever a cache access misses. It keeps the core in one of six run states (idle, running, waiting on an instruction fill, holding a fetched instruction after that fill, waiting on a data fill, and switched out). Each cycle it decides whether the core may retire an instruction. The caches, address translation and the datapath sit outside it. They reach the controller only as single-cycle request pulses: activate, stop, switch-out, instruction miss, data miss and fill done.

An instruction fill does not send the core straight back to running. It first passes through a one-cycle hold state, in which the instruction already fetched is executed and the fetch is skipped. A data fill returns to running directly. The controller also measures how long each kind of stall lasts. It records a timestamp when a miss begins and, when the fill arrives, adds the elapsed cycles to a saturating per-kind total. Any request made in a state where it is not allowed leaves the state unchanged and sets a sticky error flag.

Top module: `cpu_stall_ctrl`

## Requirements
- R1: While reset is held and after its release, the state is idle (code 0), exec_en and skip_fetch are low, both stall totals are zero and err is low.
- R2: An activate request in idle moves the state to running (code 1) in the next cycle, and exec_en first goes high act_delay cycles after that cycle (immediately when act_delay is 0). exec_en is only ever high in running or in the hold state.
- R3: A stop request in running moves the state to idle in the next cycle, holds exec_en low in the request cycle and discards any remaining activation delay.
- R4: An instruction miss in a running cycle that could execute holds exec_en low in that same cycle and moves the state to instruction stall (code 2).
- R5: A data miss keeps exec_en high in its own cycle and moves the state to data stall (code 4), where exec_en stays low.
- R6: A fill in instruction stall adds the cycles from the miss cycle to the fill cycle to istall_cnt and enters the hold state (code 3). In the hold state exec_en and skip_fetch are high for exactly one cycle and the state then becomes running.
- R7: A fill in data stall adds the cycles from the miss cycle to the fill cycle to dstall_cnt, and the next cycle is running with exec_en high.
- R8: A switch-out request from any state forces the switched-out state (code 5) in the next cycle and holds exec_en low in the request cycle. In that state, fills change neither the totals nor err, and the state is kept until reset.
- R9: An activate request outside idle, a stop outside running, a fill outside the two stall states and the switched-out state, or a miss in a cycle that cannot execute leaves the state unchanged and sets err, which stays high until reset.
- R10: Request priority is switch-out, then stop, activate, fill, instruction miss, data miss. A stop together with a miss in running goes to idle without raising err.
- R11: cnt_clr zeroes both stall totals in the next cycle and leaves the state unchanged.
- R12: Each stall total saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_req | input | 1 | Activate the context |
| act_delay | input | DLY_W | Cycles between entering running and the first execute cycle |
| stop_req | input | 1 | Suspend, deallocate or halt the context |
| swout_req | input | 1 | Switch the controller out |
| imiss | input | 1 | Instruction fetch missed this cycle |
| dmiss | input | 1 | Data access missed this cycle |
| fill_done | input | 1 | Outstanding miss completed |
| cnt_clr | input | 1 | Synchronous clear of both stall totals |
| exec_en | output | 1 | An instruction retires this cycle |
| skip_fetch | output | 1 | Retire the held instruction without a new fetch |
| state_o | output | 3 | Run state code (0 idle, 1 running, 2 instruction stall, 3 hold, 4 data stall, 5 switched out) |
| istall_cnt | output | CNT_W | Accumulated instruction stall cycles |
| dstall_cnt | output | CNT_W | Accumulated data stall cycles |
| err | output | 1 | Sticky illegal-request flag |

## Verification
exec_en and skip_fetch depend on both the current state and the requests of the same cycle. The bench therefore samples them one nanosecond after it drives the inputs at the falling edge, well before the next rising edge. The state code, the stall totals and err are registered and are due one rising edge after the request. They are read one nanosecond after that edge. Each vector of the table pairs the enables expected in the request cycle with the state expected after the edge. Stall lengths are counted from the cycle in which the miss is driven to the cycle in which the fill is driven, so the bench knows the increment exactly.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_ISTALL = 3'd2,
    ST_IHOLD  = 3'd3,
    ST_DSTALL = 3'd4,
    ST_SWOUT  = 3'd5
  } run_state_e;

  localparam int NUM_ACC = 2;
  localparam int ACC_I   = 0;
  localparam int ACC_D   = 1;
endpackage

// File: rtl/stall_fsm.sv
module stall_fsm
  import stall_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_req,
  input  logic [DLY_W-1:0]   act_delay,
  input  logic               stop_req,
  input  logic               swout_req,
  input  logic               imiss,
  input  logic               dmiss,
  input  logic               fill_done,
  output run_state_e         state_q,
  output logic               exec_en,
  output logic               skip_fetch,
  output logic               err,
  output logic [NUM_ACC-1:0] mark,
  output logic [NUM_ACC-1:0] fin
);
  run_state_e       st_d;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic             err_q, bad, can_go, exec_d;

  always_comb begin
    can_go = ((state_q == ST_RUN) && (wait_q == '0)) || (state_q == ST_IHOLD);
    st_d   = (state_q == ST_IHOLD) ? ST_RUN : state_q;
    wait_d = ((state_q == ST_RUN) && (wait_q != '0)) ? wait_q - 1'b1 : wait_q;
    exec_d = can_go;
    bad    = 1'b0;
    mark   = '0;
    fin    = '0;
    if (swout_req) begin
      st_d   = ST_SWOUT;
      wait_d = '0;
      exec_d = 1'b0;
    end else if (stop_req) begin
      if (state_q == ST_RUN) begin
        st_d   = ST_IDLE;
        wait_d = '0;
        exec_d = 1'b0;
      end else begin
        bad = 1'b1;
      end
    end else if (act_req) begin
      if (state_q == ST_IDLE) begin
        st_d   = ST_RUN;
        wait_d = act_delay;
      end else begin
        bad = 1'b1;
      end
    end else if (fill_done) begin
      if (state_q == ST_ISTALL) begin
        st_d       = ST_IHOLD;
        fin[ACC_I] = 1'b1;
      end else if (state_q == ST_DSTALL) begin
        st_d       = ST_RUN;
        fin[ACC_D] = 1'b1;
      end else if (state_q != ST_SWOUT) begin
        bad = 1'b1;
      end
    end else if (imiss) begin
      if ((state_q == ST_RUN) && (wait_q == '0)) begin
        st_d        = ST_ISTALL;
        mark[ACC_I] = 1'b1;
        exec_d      = 1'b0;
      end else begin
        bad = 1'b1;
      end
    end else if (dmiss) begin
      if (can_go) begin
        st_d        = ST_DSTALL;
        mark[ACC_D] = 1'b1;
      end else begin
        bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= st_d;
      wait_q  <= wait_d;
      if (bad) err_q <= 1'b1;
    end
  end

  assign exec_en    = exec_d;
  assign skip_fetch = exec_d && (state_q == ST_IHOLD);
  assign err        = err_q;
endmodule

// File: rtl/stall_acc.sv
module stall_acc #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mark,
  input  logic             fin,
  input  logic [CNT_W-1:0] now,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] start_q, elapsed;
  logic [CNT_W:0]   sum;

  assign elapsed = now - start_q;
  assign sum     = {1'b0, total} + {1'b0, elapsed};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (mark) begin
      start_q <= now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
    end else if (clr) begin
      total <= '0;
    end else if (fin) begin
      total <= sum[CNT_W] ? SAT : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/cpu_stall_ctrl.sv
module cpu_stall_ctrl
  import stall_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_req,
  input  logic [DLY_W-1:0] act_delay,
  input  logic             stop_req,
  input  logic             swout_req,
  input  logic             imiss,
  input  logic             dmiss,
  input  logic             fill_done,
  input  logic             cnt_clr,
  output logic             exec_en,
  output logic             skip_fetch,
  output logic [2:0]       state_o,
  output logic [CNT_W-1:0] istall_cnt,
  output logic [CNT_W-1:0] dstall_cnt,
  output logic             err
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [CNT_W-1:0]   now_q;
  run_state_e         st;
  logic [NUM_ACC-1:0] mark, fin;
  logic [CNT_W-1:0]   acc_tot [NUM_ACC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) now_q <= '0;
    else             now_q <= now_q + 1'b1;
  end

  stall_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act_req   (act_req),
    .act_delay (act_delay),
    .stop_req  (stop_req),
    .swout_req (swout_req),
    .imiss     (imiss),
    .dmiss     (dmiss),
    .fill_done (fill_done),
    .state_q   (st),
    .exec_en   (exec_en),
    .skip_fetch(skip_fetch),
    .err       (err),
    .mark      (mark),
    .fin       (fin)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    stall_acc #(.CNT_W(CNT_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .clr  (cnt_clr),
      .mark (mark[g]),
      .fin  (fin[g]),
      .now  (now_q),
      .total(acc_tot[g])
    );
  end

  assign state_o    = st;
  assign istall_cnt = acc_tot[ACC_I];
  assign dstall_cnt = acc_tot[ACC_D];
endmodule

// File: rtl/stall_ctrl_chk.sv
module stall_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             swout_req,
  input logic             cnt_clr,
  input logic             exec_en,
  input logic [2:0]       state_o,
  input logic [CNT_W-1:0] istall_cnt,
  input logic [CNT_W-1:0] dstall_cnt,
  input logic             err
);
  a_r2_exec_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> (state_o == 3'd1 || state_o == 3'd3));

  a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && stop_req && !swout_req) |=> (state_o == 3'd0));

  a_r6_hold_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |=> (state_o != 3'd3));

  a_r8_swout_enter: assert property (@(posedge clk) disable iff (!rst_n)
    swout_req |=> (state_o == 3'd5));

  a_r8_swout_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |=> (state_o == 3'd5));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (istall_cnt == '0 && dstall_cnt == '0));

  a_r12_no_wrap_i: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (istall_cnt >= $past(istall_cnt)));

  a_r12_no_wrap_d: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (dstall_cnt >= $past(dstall_cnt)));
endmodule

bind cpu_stall_ctrl stall_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .stop_req  (stop_req),
  .swout_req (swout_req),
  .cnt_clr   (cnt_clr),
  .exec_en   (exec_en),
  .state_o   (state_o),
  .istall_cnt(istall_cnt),
  .dstall_cnt(dstall_cnt),
  .err       (err)
);

// File: tb/cpu_stall_ctrl_tb.sv
module cpu_stall_ctrl_tb;
  localparam int CW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          act_req, stop_req, swout_req, imiss, dmiss, fill_done, cnt_clr;
  logic [DW-1:0] act_delay;
  logic          exec_en, skip_fetch, err;
  logic [2:0]    state_o;
  logic [CW-1:0] istall_cnt, dstall_cnt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cpu_stall_ctrl #(.CNT_W(CW), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_delay(act_delay),
    .stop_req(stop_req), .swout_req(swout_req), .imiss(imiss), .dmiss(dmiss),
    .fill_done(fill_done), .cnt_clr(cnt_clr), .exec_en(exec_en),
    .skip_fetch(skip_fetch), .state_o(state_o), .istall_cnt(istall_cnt),
    .dstall_cnt(dstall_cnt), .err(err)
  );

  typedef struct packed {
    logic          act;
    logic [DW-1:0] dly;
    logic          stop;
    logic          swo;
    logic          im;
    logic          dm;
    logic          fill;
    logic          ex;
    logic          sk;
    logic [2:0]    nst;
  } vec_t;

  //  act  dly  stop swo im dm fill | ex sk  next state
  localparam vec_t TBL [16] = '{
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R1 idle stays
    '{1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R2 activate
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R2 delay 2
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R2 delay 1
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R2 first exec
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2}, // R4 ifetch miss
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2}, // R4 stalled
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2}, // R4 stalled
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3}, // R6 fill -> hold
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R6 held insn
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4}, // R5 data miss
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4}, // R5 stalled
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1}, // R7 fill -> run
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R7 resumes
    '{1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R10 stop beats miss
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}  // R3 idle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic [DW-1:0] d, input logic s,
                       input logic w, input logic i, input logic dm,
                       input logic f, input logic c);
    @(negedge clk);
    act_req = a; act_delay = d; stop_req = s; swout_req = w;
    imiss = i; dmiss = dm; fill_done = f; cnt_clr = c;
    #1;
  endtask

  task automatic idle_cyc();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act_req = 0; act_delay = '0; stop_req = 0; swout_req = 0;
    imiss = 0; dmiss = 0; fill_done = 0; cnt_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    act_req = 0; act_delay = '0; stop_req = 0; swout_req = 0;
    imiss = 0; dmiss = 0; fill_done = 0; cnt_clr = 0;
    repeat (2) @(negedge clk);
    #1;
    // R1 during reset
    chk("R1 state in reset", state_o, 0);
    chk("R1 exec in reset", exec_en, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 state after reset", state_o, 0);
    chk("R1 istall after reset", istall_cnt, 0);
    chk("R1 dstall after reset", dstall_cnt, 0);
    chk("R1 skip after reset", skip_fetch, 0);

    foreach (TBL[k]) begin
      drive(TBL[k].act, TBL[k].dly, TBL[k].stop, TBL[k].swo, TBL[k].im,
            TBL[k].dm, TBL[k].fill, 1'b0);
      chk($sformatf("vector %0d exec_en", k), exec_en, TBL[k].ex);
      chk($sformatf("vector %0d skip_fetch", k), skip_fetch, TBL[k].sk);
      after_edge();
      chk($sformatf("vector %0d state", k), state_o, TBL[k].nst);
    end
    chk("R6 istall after 3-cycle stall", istall_cnt, 3);
    chk("R7 dstall after 2-cycle stall", dstall_cnt, 2);
    chk("R10 no err from stop with miss", err, 0);

    // R11 clear keeps state
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    after_edge();
    chk("R11 istall cleared", istall_cnt, 0);
    chk("R11 dstall cleared", dstall_cnt, 0);
    chk("R11 state kept", state_o, 0);

    // R3 stop discards pending delay
    drive(1'b1, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 exec low on stop", exec_en, 0);
    after_edge();
    chk("R3 idle after stop", state_o, 0);
    drive(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_cyc();
    chk("R3 old delay discarded", exec_en, 1);

    // R9 illegal activate while running
    drive(1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    after_edge();
    chk("R9 state unchanged", state_o, 1);
    chk("R9 err set", err, 1);
    idle_cyc();
    after_edge();
    chk("R9 err sticky", err, 1);
    chk("R9 exec unaffected", exec_en, 1);

    // R12 saturation
    do_reset();
    chk("R1 err cleared by reset", err, 0);
    drive(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 exec low on miss", exec_en, 0);
    for (int j = 0; j < 200; j++) idle_cyc();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    after_edge();
    chk("R6 istall 201", istall_cnt, 201);
    idle_cyc();
    chk("R6 hold exec", exec_en, 1);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 100; j++) idle_cyc();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    after_edge();
    chk("R12 istall saturated", istall_cnt, 255);
    idle_cyc();

    // R8 switch-out from data stall, then fill ignored
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    after_edge();
    chk("R5 in data stall", state_o, 4);
    drive(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 exec low on switch-out", exec_en, 0);
    after_edge();
    chk("R8 switched out", state_o, 5);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    after_edge();
    chk("R8 fill ignored state", state_o, 5);
    chk("R8 fill ignored err", err, 0);
    chk("R8 fill ignored dstall", dstall_cnt, 0);
    chk("R8 no exec", exec_en, 0);

    done = 1'b1;
    summary();
  end
endmodule